// File: doc/BRIEF.md
# Multi-Channel Comparator Event Timer

A memory-mapped timer block. It holds a 64-bit up-counter and three comparator channels. The counter advances on an external tick-enable strobe while the block is globally enabled. Each channel watches the low 32 bits of the counter and raises its interrupt when the counter steps onto the channel's target value. A channel can run once or reload itself, and it can signal with a single-cycle pulse or with a held level.

Software reaches the block through a simple 32-bit register port made of a valid strobe, a write flag, a word address and write data. Read data comes back from a register one clock after the access. The port exposes:

- two constant capability words,
- a global enable,
- a status word for held-level interrupts, cleared by writing ones,
- the two halves of the counter,
- one 32-byte register group per channel: configuration, route capability, comparator.

Each channel also drives a 5-bit route number that tells the interrupt fabric where its line belongs.

Top module: `cmp_event_timer`

## Requirements
- R1: Reads at offset 0x000 return 0x8086A201 and at offset 0x004 return 0x0429B17F; writes to either offset change nothing.
- R2: A write to offset 0x010 sets the global enable to bit 0 of the data when the data is 0 or 1; a write of any larger value leaves the enable unchanged; reads of 0x010 return the enable in bit 0.
- R3: Interrupt output i equals channel i's active flag ANDed with the global enable, on every cycle.
- R4: The counter steps by exactly one on each clock where tick_en is high and the global enable is set, and holds otherwise; 0x0F0 reads its low word and 0x0F4 its high word, and a carry out of the low word reaches the high word.
- R5: A write to 0x0F0 replaces only the low word and a write to 0x0F4 only the high word; in the cycle of such a write the counter does not also step.
- R6: Channel n's configuration word at 0x100+0x20*n reads bit 1 = level type, bit 2 = interrupt enable, bit 3 = periodic, bit 4 = constant 1, bits 13:9 = route, bit 14 = stored delivery flag, other bits 0; irq_route[5n+4:5n] shows the route.
- R7: A configuration write whose bit 0 is 1 leaves the whole configuration unchanged.
- R8: After reset every comparator reads 0xFFFFFFFF, the routes are 2, 8 and 0 for channels 0, 1 and 2, and the counter and global enable are 0.
- R9: A channel fires when the counter steps so that its low word equals the channel's target and the channel's interrupt enable is set; with the enable clear it never fires. Writing the comparator at +0x8 also loads the target.
- R10: An edge-type channel sets its active flag for exactly the one cycle after the step that fires it.
- R11: A level-type channel stays active after firing until a write to 0x020 has a 1 in bit n; reads of 0x020 show bit n as channel n's active flag for level-type channels only.
- R12: In periodic mode each firing advances the channel's target by the comparator value, so it fires again every comparator-value steps; the comparator itself keeps its value.
- R13: Channel offset +0x4 reads 0x000000FF, +0xC reads 0, and unmapped offsets read 0; read data appears on reg_rdata after the clock edge that samples the read and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Counter advance strobe |
| reg_valid | input | 1 | Register access strobe |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 10 | Byte offset of the word accessed |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered |
| irq_out | output | 3 | Per-channel interrupt lines |
| irq_route | output | 15 | Per-channel 5-bit route numbers, channel 0 in the low bits |

## Verification
Read data is due on the first clock edge after the edge that samples the read. Register writes take effect at the edge that samples them. A channel's active flag, and so its interrupt line, changes at the same edge where the counter steps onto the target, which is one edge after the tick strobe is presented. The bench drives inputs and samples outputs at falling edges. Its reference model updates at rising edges from the values seen there, so every output is compared half a cycle after the edge that is due to produce it, and read data is checked only on the falling edge right after a read.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;

  localparam logic [31:0] ID_WORD     = 32'h8086_A201;
  localparam logic [31:0] PERIOD_WORD = 32'h0429_B17F;
  localparam logic [31:0] ROUTE_CAP   = 32'h0000_00FF;

  localparam int OFS_ID      = 'h000;
  localparam int OFS_PERIOD  = 'h004;
  localparam int OFS_GLB     = 'h010;
  localparam int OFS_STS     = 'h020;
  localparam int OFS_CNT_LO  = 'h0F0;
  localparam int OFS_CNT_HI  = 'h0F4;
  localparam int OFS_CH_BASE = 'h100;
  localparam int CH_STRIDE   = 'h20;

  localparam int SUB_CFG = 'h0;
  localparam int SUB_CAP = 'h4;
  localparam int SUB_CMP = 'h8;

  localparam int ROUTE_W = 5;

  typedef struct packed {
    logic               fsb;
    logic [ROUTE_W-1:0] route;
    logic               periodic;
    logic               ien;
    logic               level;
  } ch_cfg_t;

  function automatic logic [ROUTE_W-1:0] reset_route(input int idx);
    case (idx)
      0:       return 5'd2;
      1:       return 5'd8;
      default: return 5'd0;
    endcase
  endfunction

  function automatic logic [31:0] cfg_to_word(input ch_cfg_t c);
    logic [31:0] w;
    w        = '0;
    w[1]     = c.level;
    w[2]     = c.ien;
    w[3]     = c.periodic;
    w[4]     = 1'b1;
    w[13:9]  = c.route;
    w[14]    = c.fsb;
    return w;
  endfunction

  function automatic ch_cfg_t word_to_cfg(input logic [31:0] w);
    ch_cfg_t c;
    c.level    = w[1];
    c.ien      = w[2];
    c.periodic = w[3];
    c.route    = w[13:9];
    c.fsb      = w[14];
    return c;
  endfunction

  function automatic logic cfg_reserved(input logic [31:0] w);
    return w[0];
  endfunction

  function automatic logic [31:0] advance_target(input logic [31:0] tgt,
                                                 input logic [31:0] period);
    return tgt + period;
  endfunction

endpackage

// File: rtl/evt_counter.sv
module evt_counter #(
  parameter int CW = 64,
  parameter int HW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          run,
  input  logic          wr_lo,
  input  logic          wr_hi,
  input  logic [HW-1:0] wdata,
  output logic [CW-1:0] cnt,
  output logic          inc,
  output logic [HW-1:0] nxt_lo
);

  localparam int UW = CW - HW;

  assign inc    = tick & run & ~(wr_lo | wr_hi);
  assign nxt_lo = cnt[HW-1:0] + {{(HW-1){1'b0}}, 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (wr_lo) begin
      cnt[HW-1:0] <= wdata;
    end else if (wr_hi) begin
      cnt[CW-1:HW] <= wdata[UW-1:0];
    end else if (inc) begin
      cnt <= cnt + {{(CW-1){1'b0}}, 1'b1};
    end
  end

endmodule

// File: rtl/evt_channel.sv
module evt_channel
  import evt_timer_pkg::*;
#(
  parameter int IDX = 0,
  parameter int DW  = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic          cmp_we,
  input  logic          clr,
  input  logic [DW-1:0] wdata,
  input  logic          inc,
  input  logic [DW-1:0] nxt_lo,
  output ch_cfg_t       cfg,
  output logic [DW-1:0] cmp,
  output logic [DW-1:0] tgt,
  output logic          fire,
  output logic          active,
  output logic          cfg_rsvd
);

  assign cfg_rsvd = cfg_we & cfg_reserved(wdata);
  assign fire     = cfg.ien & inc & (nxt_lo == tgt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg.fsb      <= 1'b0;
      cfg.route    <= reset_route(IDX);
      cfg.periodic <= 1'b0;
      cfg.ien      <= 1'b0;
      cfg.level    <= 1'b0;
    end else if (cfg_we && !cfg_reserved(wdata)) begin
      cfg <= word_to_cfg(wdata);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp <= '1;
      tgt <= '1;
    end else if (cmp_we) begin
      cmp <= wdata;
      tgt <= wdata;
    end else if (fire && cfg.periodic) begin
      tgt <= advance_target(tgt, cmp);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
    end else if (cfg.level) begin
      active <= fire | (active & ~clr);
    end else begin
      active <= fire;
    end
  end

endmodule

// File: rtl/evt_regfile.sv
module evt_regfile
  import evt_timer_pkg::*;
#(
  parameter int NCH = 3,
  parameter int AW  = 10,
  parameter int CW  = 64
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  valid,
  input  logic                  write,
  input  logic [AW-1:0]         addr,
  input  logic [31:0]           wdata,
  input  logic [CW-1:0]         cnt,
  input  logic [NCH-1:0][31:0]  cfg_words,
  input  logic [NCH-1:0][31:0]  cmp_vals,
  input  logic [NCH-1:0]        sts,
  output logic                  glb_en,
  output logic                  wr_lo,
  output logic                  wr_hi,
  output logic [NCH-1:0]        cfg_we,
  output logic [NCH-1:0]        cmp_we,
  output logic [NCH-1:0]        clr,
  output logic [31:0]           rdata
);

  localparam int CH_END = OFS_CH_BASE + CH_STRIDE * NCH;

  logic        wr_acc;
  logic        rd_acc;
  logic        in_ch;
  int          a_i;
  int          ch_idx;
  int          sub;
  logic [31:0] sts_word;
  logic [31:0] cnt_hi_word;
  logic [31:0] ch_cfg_word;
  logic [31:0] ch_cmp_word;
  logic [31:0] rd_word;

  assign wr_acc      = valid & write;
  assign rd_acc      = valid & ~write;
  assign cnt_hi_word = 32'(cnt >> 32);

  always_comb begin
    a_i    = int'(addr);
    in_ch  = (a_i >= OFS_CH_BASE) && (a_i < CH_END);
    ch_idx = (a_i - OFS_CH_BASE) / CH_STRIDE;
    sub    = (a_i - OFS_CH_BASE) % CH_STRIDE;
  end

  assign wr_lo = wr_acc && (a_i == OFS_CNT_LO);
  assign wr_hi = wr_acc && (a_i == OFS_CNT_HI);

  for (genvar g = 0; g < NCH; g++) begin : g_dec
    assign cfg_we[g] = wr_acc && in_ch && (ch_idx == g) && (sub == SUB_CFG);
    assign cmp_we[g] = wr_acc && in_ch && (ch_idx == g) && (sub == SUB_CMP);
    assign clr[g]    = wr_acc && (a_i == OFS_STS) && wdata[g];
  end

  always_comb begin
    sts_word          = '0;
    sts_word[NCH-1:0] = sts;
  end

  always_comb begin
    ch_cfg_word = '0;
    ch_cmp_word = '0;
    for (int k = 0; k < NCH; k++) begin
      if (k == ch_idx) begin
        ch_cfg_word = cfg_words[k];
        ch_cmp_word = cmp_vals[k];
      end
    end
  end

  always_comb begin
    rd_word = '0;
    if (in_ch) begin
      case (sub)
        SUB_CFG: rd_word = ch_cfg_word;
        SUB_CAP: rd_word = ROUTE_CAP;
        SUB_CMP: rd_word = ch_cmp_word;
        default: rd_word = '0;
      endcase
    end else begin
      case (a_i)
        OFS_ID:     rd_word = ID_WORD;
        OFS_PERIOD: rd_word = PERIOD_WORD;
        OFS_GLB:    rd_word = {31'd0, glb_en};
        OFS_STS:    rd_word = sts_word;
        OFS_CNT_LO: rd_word = cnt[31:0];
        OFS_CNT_HI: rd_word = cnt_hi_word;
        default:    rd_word = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      glb_en <= 1'b0;
    end else if (wr_acc && (a_i == OFS_GLB) && (wdata < 32'd2)) begin
      glb_en <= wdata[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= '0;
    end else if (rd_acc) begin
      rdata <= rd_word;
    end
  end

endmodule

// File: rtl/cmp_event_timer.sv
module cmp_event_timer
  import evt_timer_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int ADDR_W = 10,
  parameter int CNT_W  = 64
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        tick_en,
  input  logic                        reg_valid,
  input  logic                        reg_write,
  input  logic [ADDR_W-1:0]           reg_addr,
  input  logic [31:0]                 reg_wdata,
  output logic [31:0]                 reg_rdata,
  output logic [NUM_CH-1:0]           irq_out,
  output logic [NUM_CH*ROUTE_W-1:0]   irq_route
);

  logic [CNT_W-1:0]          cnt_q;
  logic                      cnt_inc;
  logic                      cnt_wr;
  logic [31:0]               cnt_nxt_lo;
  logic                      glb_en;
  logic                      wr_lo;
  logic                      wr_hi;
  logic [NUM_CH-1:0]         cfg_we;
  logic [NUM_CH-1:0]         cfg_rsvd;
  logic [NUM_CH-1:0]         cmp_we;
  logic [NUM_CH-1:0]         clr_w;
  logic [NUM_CH-1:0]         fire_w;
  logic [NUM_CH-1:0]         act_w;
  logic [NUM_CH-1:0]         lvl_w;
  logic [NUM_CH-1:0]         per_w;
  logic [NUM_CH-1:0]         sts_w;
  logic [NUM_CH-1:0][31:0]   cfg_words;
  logic [NUM_CH-1:0][31:0]   cmp_vals;
  logic [NUM_CH-1:0][31:0]   tgt_vals;
  ch_cfg_t                   ch_cfg [NUM_CH];

  assign cnt_wr = wr_lo | wr_hi;

  evt_counter #(.CW(CNT_W), .HW(32)) u_counter (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tick_en),
    .run    (glb_en),
    .wr_lo  (wr_lo),
    .wr_hi  (wr_hi),
    .wdata  (reg_wdata),
    .cnt    (cnt_q),
    .inc    (cnt_inc),
    .nxt_lo (cnt_nxt_lo)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    evt_channel #(.IDX(g), .DW(32)) u_ch (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg_we   (cfg_we[g]),
      .cmp_we   (cmp_we[g]),
      .clr      (clr_w[g]),
      .wdata    (reg_wdata),
      .inc      (cnt_inc),
      .nxt_lo   (cnt_nxt_lo),
      .cfg      (ch_cfg[g]),
      .cmp      (cmp_vals[g]),
      .tgt      (tgt_vals[g]),
      .fire     (fire_w[g]),
      .active   (act_w[g]),
      .cfg_rsvd (cfg_rsvd[g])
    );
    assign cfg_words[g] = cfg_to_word(ch_cfg[g]);
    assign lvl_w[g]     = ch_cfg[g].level;
    assign per_w[g]     = ch_cfg[g].periodic;
    assign sts_w[g]     = act_w[g] & ch_cfg[g].level;
    assign irq_route[g*ROUTE_W +: ROUTE_W] = ch_cfg[g].route;
  end

  evt_regfile #(.NCH(NUM_CH), .AW(ADDR_W), .CW(CNT_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .valid     (reg_valid),
    .write     (reg_write),
    .addr      (reg_addr),
    .wdata     (reg_wdata),
    .cnt       (cnt_q),
    .cfg_words (cfg_words),
    .cmp_vals  (cmp_vals),
    .sts       (sts_w),
    .glb_en    (glb_en),
    .wr_lo     (wr_lo),
    .wr_hi     (wr_hi),
    .cfg_we    (cfg_we),
    .cmp_we    (cmp_we),
    .clr       (clr_w),
    .rdata     (reg_rdata)
  );

  assign irq_out = act_w & {NUM_CH{glb_en}};

endmodule

// File: rtl/evt_timer_checks.sv
module evt_timer_checks #(
  parameter int NCH = 3,
  parameter int CW  = 64
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [CW-1:0]        cnt,
  input logic                 cnt_inc,
  input logic                 cnt_wr,
  input logic [NCH-1:0]       fire,
  input logic [NCH-1:0]       act,
  input logic [NCH-1:0]       lvl,
  input logic [NCH-1:0]       per,
  input logic [NCH-1:0]       clr,
  input logic [NCH-1:0]       cfg_we,
  input logic [NCH-1:0]       cfg_rsvd,
  input logic [NCH-1:0]       cmp_we,
  input logic [NCH-1:0][31:0] cmp_vals,
  input logic [NCH-1:0][31:0] tgt_vals,
  input logic [NCH-1:0][31:0] cfg_words
);

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_inc |=> (cnt == $past(cnt) + {{(CW-1){1'b0}}, 1'b1})); // R4

  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_inc && !cnt_wr) |=> $stable(cnt)); // R4

  for (genvar g = 0; g < NCH; g++) begin : g_chk
    AST_FIRE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      fire[g] |=> act[g]); // R9

    AST_EDGE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (!lvl[g] && !fire[g]) |=> !act[g]); // R10

    AST_LVL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (act[g] && lvl[g] && !clr[g] && !cfg_we[g]) |=> act[g]); // R11

    AST_RSVD_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_rsvd[g] |=> $stable(cfg_words[g])); // R7

    AST_PERIOD_ADV: assert property (@(posedge clk) disable iff (!rst_n)
      (fire[g] && per[g] && !cmp_we[g]) |=>
        (tgt_vals[g] == $past(tgt_vals[g]) + $past(cmp_vals[g]))); // R12
  end

endmodule

bind cmp_event_timer evt_timer_checks #(.NCH(NUM_CH), .CW(CNT_W)) u_evt_checks (
  .clk       (clk),
  .rst_n     (rst_n),
  .cnt       (cnt_q),
  .cnt_inc   (cnt_inc),
  .cnt_wr    (cnt_wr),
  .fire      (fire_w),
  .act       (act_w),
  .lvl       (lvl_w),
  .per       (per_w),
  .clr       (clr_w),
  .cfg_we    (cfg_we),
  .cfg_rsvd  (cfg_rsvd),
  .cmp_we    (cmp_we),
  .cmp_vals  (cmp_vals),
  .tgt_vals  (tgt_vals),
  .cfg_words (cfg_words)
);

// File: tb/cmp_event_timer_bench.sv
module cmp_event_timer_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic        reg_valid = 1'b0;
  logic        reg_write = 1'b0;
  logic [9:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [2:0]  irq_out;
  logic [14:0] irq_route;

  int    n_checks = 0;
  int    n_errors = 0;
  bit    done = 1'b0;
  string rd_tag = "R13";

  always #2 clk = ~clk;

  cmp_event_timer u_cmp_event_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_en   (tick_en),
    .reg_valid (reg_valid),
    .reg_write (reg_write),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .irq_out   (irq_out),
    .irq_route (irq_route)
  );

  // ---------------- behavioural reference model ----------------
  logic [63:0] m_cnt;
  bit          m_glb;
  logic [31:0] m_cmp [3];
  logic [31:0] m_tgt [3];
  bit          m_lvl [3];
  bit          m_ien [3];
  bit          m_per [3];
  bit          m_fsb [3];
  logic [4:0]  m_route [3];
  bit          m_act [3];
  logic [31:0] exp_rd;
  bit          rd_due;

  task automatic m_reset();
    m_cnt = 0;
    m_glb = 0;
    rd_due = 0;
    for (int i = 0; i < 3; i++) begin
      m_cmp[i] = 32'hFFFF_FFFF;
      m_tgt[i] = 32'hFFFF_FFFF;
      m_lvl[i] = 0; m_ien[i] = 0; m_per[i] = 0; m_fsb[i] = 0; m_act[i] = 0;
    end
    m_route[0] = 5'd2; m_route[1] = 5'd8; m_route[2] = 5'd0;
  endtask

  function automatic logic [31:0] m_read(input int a);
    logic [31:0] v;
    int c;
    int s;
    v = 0;
    if (a == 0) v = 32'h8086_A201;
    else if (a == 4) v = 32'h0429_B17F;
    else if (a == 16) v = {31'd0, m_glb};
    else if (a == 32) begin
      for (int i = 0; i < 3; i++) if (m_lvl[i] && m_act[i]) v[i] = 1'b1;
    end
    else if (a == 240) v = m_cnt[31:0];
    else if (a == 244) v = m_cnt[63:32];
    else if (a >= 256 && a < 352) begin
      c = (a - 256) / 32;
      s = (a - 256) % 32;
      if (s == 0)
        v = (32'(m_fsb[c]) << 14) | (32'(m_route[c]) << 9) | 32'd16 |
            (32'(m_per[c]) << 3) | (32'(m_ien[c]) << 2) | (32'(m_lvl[c]) << 1);
      else if (s == 4) v = 32'hFF;
      else if (s == 8) v = m_cmp[c];
    end
    return v;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_reset();
    end else begin
      int a;
      bit wr;
      bit cw;
      bit inc;
      bit fire [3];
      logic [31:0] nl;
      a  = int'(reg_addr);
      wr = reg_valid && reg_write;
      if (reg_valid && !reg_write) begin
        exp_rd = m_read(a);
        rd_due = 1;
      end else begin
        rd_due = 0;
      end
      cw  = wr && (a == 240 || a == 244);
      inc = tick_en && m_glb && !cw;
      nl  = m_cnt[31:0] + 32'd1;
      for (int i = 0; i < 3; i++) fire[i] = m_ien[i] && inc && (nl == m_tgt[i]);
      for (int i = 0; i < 3; i++) begin
        bit clr;
        clr = wr && (a == 32) && reg_wdata[i];
        if (m_lvl[i]) m_act[i] = fire[i] || (m_act[i] && !clr);
        else m_act[i] = fire[i];
        if (wr && a == 256 + 32 * i + 8) begin
          m_cmp[i] = reg_wdata;
          m_tgt[i] = reg_wdata;
        end else if (fire[i] && m_per[i]) begin
          m_tgt[i] = m_tgt[i] + m_cmp[i];
        end
        if (wr && a == 256 + 32 * i && !reg_wdata[0]) begin
          m_lvl[i]   = reg_wdata[1];
          m_ien[i]   = reg_wdata[2];
          m_per[i]   = reg_wdata[3];
          m_route[i] = reg_wdata[13:9];
          m_fsb[i]   = reg_wdata[14];
        end
      end
      if (wr && a == 16 && reg_wdata < 2) m_glb = reg_wdata[0];
      if (wr && a == 240) m_cnt[31:0] = reg_wdata;
      else if (wr && a == 244) m_cnt[63:32] = reg_wdata;
      else if (inc) m_cnt = m_cnt + 64'd1;
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-clock comparison against the model, half a cycle after each edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [2:0]  e_irq;
      logic [14:0] e_rt;
      for (int i = 0; i < 3; i++) begin
        e_irq[i] = m_act[i] && m_glb;
        e_rt[i*5 +: 5] = m_route[i];
      end
      chk("R3 irq_out", {61'd0, irq_out}, {61'd0, e_irq});
      chk("R6 irq_route", {49'd0, irq_route}, {49'd0, e_rt});
      if (rd_due) chk(rd_tag, {32'd0, reg_rdata}, {32'd0, exp_rd});
    end
  end

  // ---------------- stimulus ----------------
  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    reg_valid = 1; reg_write = 1; reg_addr = 10'(a); reg_wdata = d;
    @(negedge clk);
    reg_valid = 0; reg_write = 0;
  endtask

  task automatic rd(input int a, input string tag);
    @(negedge clk);
    rd_tag = tag;
    reg_valid = 1; reg_write = 0; reg_addr = 10'(a);
    @(negedge clk);
    reg_valid = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int p0;
    int p1;
    int p2;
    idle(5);
    rst_n = 1;
    idle(1);

    // R8 reset state
    chk("R8 routes", {49'd0, irq_route}, {49'd0, 15'h0102});
    rd(32'h108, "R8"); chk("R8 cmp0", {32'd0, reg_rdata}, 64'hFFFF_FFFF);
    rd(32'h128, "R8");
    rd(32'h148, "R8"); chk("R8 cmp2", {32'd0, reg_rdata}, 64'hFFFF_FFFF);
    rd(32'h0F0, "R8"); rd(32'h010, "R8");

    // R1 constants and ignored writes
    wr(32'h000, 32'h0); wr(32'h004, 32'h1234);
    rd(32'h000, "R1"); chk("R1 id", {32'd0, reg_rdata}, 64'h8086_A201);
    rd(32'h004, "R1"); chk("R1 period", {32'd0, reg_rdata}, 64'h0429_B17F);

    // R2 / R4: disabled counter holds, large enable value dropped
    tick_en = 1; idle(5); tick_en = 0;
    rd(32'h0F0, "R4"); chk("R4 hold", {32'd0, reg_rdata}, 64'd0);
    wr(32'h010, 32'd5); rd(32'h010, "R2"); chk("R2 drop", {32'd0, reg_rdata}, 64'd0);
    wr(32'h010, 32'd1); rd(32'h010, "R2"); chk("R2 set", {32'd0, reg_rdata}, 64'd1);
    tick_en = 1; idle(10); tick_en = 0;
    rd(32'h0F0, "R4"); chk("R4 step", {32'd0, reg_rdata}, 64'd10);
    wr(32'h010, 32'd3); rd(32'h010, "R2"); chk("R2 keep", {32'd0, reg_rdata}, 64'd1);

    // R5 split halves, write wins over tick, carry into high word
    wr(32'h0F4, 32'h1234_5678);
    rd(32'h0F0, "R5"); chk("R5 low kept", {32'd0, reg_rdata}, 64'd10);
    tick_en = 1;
    wr(32'h0F0, 32'hFFFF_FFF0);
    idle(19);
    tick_en = 0;
    rd(32'h0F4, "R5"); chk("R5 carry", {32'd0, reg_rdata}, 64'h1234_5679);
    rd(32'h0F0, "R5");

    // R6 / R7 configuration layout and reserved write
    wr(32'h120, 32'h0000_4E0C);
    rd(32'h120, "R6"); chk("R6 cfg", {32'd0, reg_rdata}, 64'h0000_4E1C);
    chk("R6 route1", {59'd0, irq_route[9:5]}, 64'd7);
    wr(32'h120, 32'h0000_0003);
    rd(32'h120, "R7"); chk("R7 rsvd", {32'd0, reg_rdata}, 64'h0000_4E1C);

    // R9 / R10 / R11 edge and level firing
    wr(32'h0F0, 0); wr(32'h0F4, 0);
    wr(32'h108, 32'd20); wr(32'h100, 32'h4);
    wr(32'h148, 32'd20); wr(32'h140, 32'h0);
    wr(32'h128, 32'd30); wr(32'h120, 32'h6);
    p0 = 0; p2 = 0;
    tick_en = 1;
    repeat (40) begin
      @(negedge clk);
      p0 += int'(irq_out[0]);
      p2 += int'(irq_out[2]);
    end
    tick_en = 0;
    chk("R10 one pulse", 64'(p0), 64'd1);
    chk("R9 disabled silent", 64'(p2), 64'd0);
    chk("R11 held", {63'd0, irq_out[1]}, 64'd1);
    rd(32'h020, "R11"); chk("R11 status", {32'd0, reg_rdata}, 64'd2);
    wr(32'h010, 32'd0);
    chk("R3 gated", {61'd0, irq_out}, 64'd0);
    wr(32'h010, 32'd1);
    chk("R3 ungated", {61'd0, irq_out}, 64'd2);
    wr(32'h020, 32'h7);
    rd(32'h020, "R11"); chk("R11 cleared", {32'd0, reg_rdata}, 64'd0);

    // R12 periodic reload
    wr(32'h100, 32'h0);
    wr(32'h0F0, 0);
    wr(32'h148, 32'd8); wr(32'h140, 32'h0000_060C);
    p1 = 0;
    tick_en = 1;
    repeat (30) begin
      @(negedge clk);
      p1 += int'(irq_out[2]);
    end
    tick_en = 0;
    chk("R12 period pulses", 64'(p1), 64'd3);
    rd(32'h148, "R12"); chk("R12 cmp kept", {32'd0, reg_rdata}, 64'd8);

    // R13 capability, reserved and unmapped reads
    rd(32'h104, "R13"); chk("R13 cap", {32'd0, reg_rdata}, 64'hFF);
    rd(32'h10C, "R13");
    rd(32'h030, "R13");
    rd(32'h160, "R13");
    rd(32'h3FC, "R13"); chk("R13 unmapped", {32'd0, reg_rdata}, 64'd0);
    idle(2);
    chk("R13 hold", {32'd0, reg_rdata}, 64'd0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_checks++;
      n_errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

endmodule